// File: doc/BRIEF.md
# Serial Receive Buffer with Register Port

This block is the receive side of a memory-mapped serial port. An external deserializer hands it one character per accepted beat: eight data bits with four error bits above them. Characters wait in a circular buffer that runs either as a 16-slot queue or as a one-slot holding register. A line-control bit picks the mode. Software reads the characters through a word-addressed register port. The same port holds the divisor, control and level-select storage that the wider serial port uses.

The block keeps two status flags, buffer-empty and buffer-full. A level-sensitive receive interrupt rises when the fill count reaches a programmable threshold. It drops when a data read leaves the count one below that threshold. A mask register gates the raw bit onto a single interrupt line. The top eight words of the address space hold a read-only identification window, filled from a parameter.

Top module: `serial_rx_port`

## Requirements
- R1: After reset the buffer is empty. The empty flag is 1, the full flag is 0, `irq` is 0, `rx_ready` is 1, the line word (11) reads 0 and the level-select word (13) reads 0x12.
- R2: When line-word bit 4 is 1, `rx_ready` is high while fewer than 16 characters are held. When that bit is 0, `rx_ready` is high only while the buffer is empty. A beat with `rx_valid` high and `rx_ready` low is dropped.
- R3: An accepted character clears the empty flag. It sets the full flag when the count reaches 16, and on every accepted character while bit 4 is 0. Flags word 6 shows empty at bit 4 and full at bit 6.
- R4: A read of word 0 returns the oldest character in bits 11:0 and removes it. The read clears the full flag and copies bits 11:8 of that character into word 1, bits 3:0.
- R5: A read of word 0 with the buffer empty returns the last character removed. It leaves the count at zero and the empty flag set.
- R6: Word 13 bits 5:3 select the threshold: 0→2, 1→4, 2→8, 3→12, any other value→14. The threshold is 1 while bit 4 of the line word is 0. Raw status bit 4 (word 15) is set when an accepted character makes the count equal to the threshold. It is cleared when a data read leaves the count at threshold minus one.
- R7: Mask word 14 bit 4 gates the receive bit. Word 16 reads raw AND mask. `irq` is high when any masked bit is set, from the cycle after the mask write.
- R8: Words 8, 9, 10, 11, 12, 13, 14 and 18 read back the last value written, cut to 8, 16, 6, 8, 16, 6, 11 and 3 bits.
- R9: Words 0x3F8 to 0x3FF return byte (word − 0x3F8) of `ID_BYTES`, where byte k is bits 8k+7:8k. Every other unmapped word reads 0. Writes to words 0, 1, 6, 15, 16 and unmapped words change nothing.
- R10: A write to word 11 that changes bit 4 empties the buffer and clears the full flag and the raw receive bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_valid | input | 1 | Character beat valid |
| rx_char | input | 12 | Error bits [11:8] and data bits [7:0] |
| rx_ready | output | 1 | Buffer can take a character |
| reg_sel | input | 1 | Register access this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 10 | Word index |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the cycle of the read |
| rx_full | output | 1 | Buffer-full flag |
| rx_empty | output | 1 | Buffer-empty flag |
| irq | output | 1 | Combined masked interrupt |

## Verification
A wrong fill count shows up at once on `rx_ready` and `rx_empty`. If it is off by one, `irq` also rises one character early or late against the threshold. A stale read pointer shows as a wrong character on the next word-0 read. A wrong error-bit latch shows up only at the following word-1 read. Because the bench compares every read and every flag on every cycle, a corrupted slot, a missed flush or an unmasked interrupt is caught within the cycle in which it first reaches a port.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [9:0] {
        W_DATA  = 10'd0,
        W_STAT  = 10'd1,
        W_FLAG  = 10'd6,
        W_LPDIV = 10'd8,
        W_IDIV  = 10'd9,
        W_FDIV  = 10'd10,
        W_LINE  = 10'd11,
        W_CTRL  = 10'd12,
        W_LVL   = 10'd13,
        W_MASK  = 10'd14,
        W_RAW   = 10'd15,
        W_MSKD  = 10'd16,
        W_DMAC  = 10'd18
    } srx_word_e;

    localparam int FLAG_EMPTY_BIT = 4;
    localparam int FLAG_FULL_BIT  = 6;
    localparam int INT_RX_BIT     = 4;
    localparam int LINE_FEN_BIT   = 4;

    localparam int LPDIV_W = 8;
    localparam int IDIV_W  = 16;
    localparam int FDIV_W  = 6;
    localparam int LINE_W  = 8;
    localparam int CTRL_W  = 16;
    localparam int LVL_W   = 6;
    localparam int MASK_W  = 11;
    localparam int DMAC_W  = 3;

    localparam logic [LVL_W-1:0] LVL_RESET = 6'h12;

endpackage

// File: rtl/srx_fifo.sv
module srx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 12,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    input  logic             single,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count
);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t s_q, s_d;
    logic [WIDTH-1:0] mem_q [DEPTH];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d = '0;
        end else begin
            if (push) s_d.wr = single ? '0 : step(s_q.wr);
            if (pop)  s_d.rd = single ? '0 : step(s_q.rd);
            s_d.cnt = s_q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem_q[s_q.wr] <= wdata;
    end

    assign head  = mem_q[s_q.rd];
    assign count = s_q.cnt;

endmodule

// File: rtl/srx_trig.sv
module srx_trig #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [2:0]    level_sel,
    input  logic          fifo_on,
    output logic [CW-1:0] trig
);

    always_comb begin
        case (level_sel)
            3'd0:    trig = CW'(DEPTH / 8);
            3'd1:    trig = CW'(DEPTH / 4);
            3'd2:    trig = CW'(DEPTH / 2);
            3'd3:    trig = CW'((DEPTH * 3) / 4);
            default: trig = CW'((DEPTH * 7) / 8);
        endcase
        if (!fifo_on) trig = CW'(1);
    end

endmodule

// File: rtl/srx_idrom.sv
module srx_idrom #(
    parameter int N = 8,
    parameter logic [8*N-1:0] BYTES = '0,
    localparam int IW = $clog2(N)
) (
    input  logic [IW-1:0] idx,
    output logic [7:0]    byte_o
);

    logic [7:0] tbl [N];

    for (genvar i = 0; i < N; i++) begin : g_byte
        assign tbl[i] = BYTES[8*i +: 8];
    end

    assign byte_o = tbl[idx];

endmodule

// File: rtl/serial_rx_port.sv
module serial_rx_port
    import srx_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    parameter int ERR_W  = 4,
    parameter int ADDR_W = 10,
    parameter int REG_W  = 16,
    parameter int ID_N   = 8,
    parameter logic [8*ID_N-1:0] ID_BYTES = 64'hB105_F00D_0024_1011,
    localparam int CHAR_W = DATA_W + ERR_W,
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int IW     = $clog2(ID_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    output logic              rx_ready,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              rx_full,
    output logic              rx_empty,
    output logic              irq
);

    typedef struct packed {
        logic [LPDIV_W-1:0] lpdiv;
        logic [IDIV_W-1:0]  idiv;
        logic [FDIV_W-1:0]  fdiv;
        logic [LINE_W-1:0]  line;
        logic [CTRL_W-1:0]  ctrl;
        logic [LVL_W-1:0]   lvl;
        logic [MASK_W-1:0]  mask;
        logic [DMAC_W-1:0]  dmac;
        logic               raw_rx;
        logic               full;
        logic [ERR_W-1:0]   stat;
        logic [CHAR_W-1:0]  last;
    } regs_t;

    regs_t r_q, r_d;

    logic              fen;
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     cnt_after;
    logic [CW-1:0]     trig;
    logic [CHAR_W-1:0] head;
    logic              push, pop, flush;
    logic              rd_acc, wr_acc, rd_dat;
    logic              raw_rx_q, mask_rx;
    logic [MASK_W-1:0] raw_vec, mskd_vec;
    logic              id_hit;
    logic [7:0]        id_byte;

    assign fen      = r_q.line[LINE_FEN_BIT];
    assign rd_acc   = reg_sel && !reg_we;
    assign wr_acc   = reg_sel && reg_we;
    assign rd_dat   = rd_acc && (reg_addr == ADDR_W'(W_DATA));
    assign rx_ready = fen ? (cnt < CW'(DEPTH)) : (cnt == '0);
    assign push     = rx_valid && rx_ready;
    assign pop      = rd_dat && (cnt != '0);
    assign flush    = wr_acc && (reg_addr == ADDR_W'(W_LINE))
                      && (reg_wdata[LINE_FEN_BIT] != fen);
    assign cnt_after = cnt + CW'(push) - CW'(pop);

    srx_fifo #(.DEPTH(DEPTH), .WIDTH(CHAR_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .flush (flush),
        .single(!fen),
        .wdata (rx_char),
        .head  (head),
        .count (cnt)
    );

    srx_trig #(.DEPTH(DEPTH)) u_trig (
        .level_sel(r_q.lvl[5:3]),
        .fifo_on  (fen),
        .trig     (trig)
    );

    srx_idrom #(.N(ID_N), .BYTES(ID_BYTES)) u_id (
        .idx   (reg_addr[IW-1:0]),
        .byte_o(id_byte)
    );

    // next-state of the register set
    always_comb begin
        r_d = r_q;
        if (wr_acc) begin
            case (reg_addr)
                ADDR_W'(W_LPDIV): r_d.lpdiv = reg_wdata[LPDIV_W-1:0];
                ADDR_W'(W_IDIV):  r_d.idiv  = reg_wdata[IDIV_W-1:0];
                ADDR_W'(W_FDIV):  r_d.fdiv  = reg_wdata[FDIV_W-1:0];
                ADDR_W'(W_LINE):  r_d.line  = reg_wdata[LINE_W-1:0];
                ADDR_W'(W_CTRL):  r_d.ctrl  = reg_wdata[CTRL_W-1:0];
                ADDR_W'(W_LVL):   r_d.lvl   = reg_wdata[LVL_W-1:0];
                ADDR_W'(W_MASK):  r_d.mask  = reg_wdata[MASK_W-1:0];
                ADDR_W'(W_DMAC):  r_d.dmac  = reg_wdata[DMAC_W-1:0];
                default: ;
            endcase
        end
        if (flush) begin
            r_d.full   = 1'b0;
            r_d.raw_rx = 1'b0;
        end else begin
            if (rd_dat) r_d.full = 1'b0;
            if (push && (!fen || cnt_after == CW'(DEPTH))) r_d.full = 1'b1;
            if (push && cnt_after == trig)
                r_d.raw_rx = 1'b1;
            else if (pop && cnt_after == CW'(trig - 1'b1))
                r_d.raw_rx = 1'b0;
            if (pop) begin
                r_d.last = head;
                r_d.stat = head[CHAR_W-1:DATA_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.lvl <= LVL_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign raw_rx_q = r_q.raw_rx;
    assign mask_rx  = r_q.mask[INT_RX_BIT];
    assign raw_vec  = MASK_W'(r_q.raw_rx) << INT_RX_BIT;
    assign mskd_vec = raw_vec & r_q.mask;
    assign irq      = |mskd_vec;
    assign rx_full  = r_q.full;
    assign rx_empty = (cnt == '0);
    assign id_hit   = (reg_addr[ADDR_W-1:IW] == {(ADDR_W-IW){1'b1}});

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (rd_acc) begin
            if (id_hit) begin
                reg_rdata = REG_W'(id_byte);
            end else begin
                case (reg_addr)
                    ADDR_W'(W_DATA):  reg_rdata = REG_W'((cnt != '0) ? head : r_q.last);
                    ADDR_W'(W_STAT):  reg_rdata = REG_W'(r_q.stat);
                    ADDR_W'(W_FLAG): begin
                        reg_rdata[FLAG_EMPTY_BIT] = rx_empty;
                        reg_rdata[FLAG_FULL_BIT]  = r_q.full;
                    end
                    ADDR_W'(W_LPDIV): reg_rdata = REG_W'(r_q.lpdiv);
                    ADDR_W'(W_IDIV):  reg_rdata = REG_W'(r_q.idiv);
                    ADDR_W'(W_FDIV):  reg_rdata = REG_W'(r_q.fdiv);
                    ADDR_W'(W_LINE):  reg_rdata = REG_W'(r_q.line);
                    ADDR_W'(W_CTRL):  reg_rdata = REG_W'(r_q.ctrl);
                    ADDR_W'(W_LVL):   reg_rdata = REG_W'(r_q.lvl);
                    ADDR_W'(W_MASK):  reg_rdata = REG_W'(r_q.mask);
                    ADDR_W'(W_RAW):   reg_rdata = REG_W'(raw_vec);
                    ADDR_W'(W_MSKD):  reg_rdata = REG_W'(mskd_vec);
                    ADDR_W'(W_DMAC):  reg_rdata = REG_W'(r_q.dmac);
                    default:          reg_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/srx_chk.sv
module srx_chk #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 10,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              reg_sel,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              wdata_fen,
    input logic              rx_full,
    input logic              rx_empty,
    input logic              irq,
    input logic              fen,
    input logic [CW-1:0]     cnt
);

    logic rd_data_word;
    logic line_toggle;
    assign rd_data_word = reg_sel && !reg_we && (reg_addr == '0);
    assign line_toggle  = reg_sel && reg_we && (reg_addr == ADDR_W'(11)) && (wdata_fen != fen);

    // R2: single-slot mode never offers space while holding a character
    a_r2_single_holds_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!fen && !rx_empty) |-> !rx_ready);

    // R2: the count never exceeds the depth
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R3: an accepted character in single-slot mode raises the full flag
    a_r3_single_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && !fen && !(reg_sel && reg_we)) |=> rx_full);

    // R4: a data read without a concurrent accept leaves the full flag low
    a_r4_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_word && !(rx_valid && rx_ready)) |=> !rx_full);

    // R5: reading an empty buffer does not underflow it
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_word && rx_empty && !rx_valid) |=> rx_empty);

    // R10: a mode toggle leaves the buffer empty and the interrupt low
    a_r10_toggle_flush: assert property (@(posedge clk) disable iff (!rst_n)
        line_toggle |=> (rx_empty && !rx_full && !irq));

endmodule

bind serial_rx_port srx_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .reg_sel  (reg_sel),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .wdata_fen(reg_wdata[4]),
    .rx_full  (rx_full),
    .rx_empty (rx_empty),
    .irq      (irq),
    .fen      (fen),
    .cnt      (cnt)
);

// File: tb/sim_serial_rx_port.sv
module sim_serial_rx_port;

    localparam int P = 10;
    localparam logic [63:0] IDB = 64'hB105_F00D_0024_1011;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [11:0] rx_char = '0;
    logic        rx_ready;
    logic        reg_sel = 1'b0;
    logic        reg_we = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        rx_full, rx_empty, irq;

    int checks = 0;
    int errors = 0;

    // model state
    logic [11:0] q [16];
    int          qh, qn;
    logic [7:0]  m_lpdiv, m_line;
    logic [15:0] m_idiv, m_ctrl;
    logic [5:0]  m_fdiv, m_lvl;
    logic [10:0] m_mask;
    logic [2:0]  m_dmac;
    logic        m_raw, m_full;
    logic [3:0]  m_stat;
    logic [11:0] m_last;

    serial_rx_port u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
        .rx_ready(rx_ready), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_full(rx_full), .rx_empty(rx_empty), .irq(irq)
    );

    always #(P/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic bit m_fen();
        return m_line[4];
    endfunction

    function automatic int m_trig();
        if (!m_fen()) return 1;
        case (m_lvl[5:3])
            3'd0: return 2;
            3'd1: return 4;
            3'd2: return 8;
            3'd3: return 12;
            default: return 14;
        endcase
    endfunction

    function automatic bit m_ready();
        return m_fen() ? (qn < 16) : (qn == 0);
    endfunction

    function automatic logic [15:0] m_read(input logic [9:0] a);
        if (a >= 10'h3F8) return 16'(IDB[8*(a-10'h3F8) +: 8]);
        case (a)
            10'd0:  return 16'((qn > 0) ? q[qh] : m_last);
            10'd1:  return 16'(m_stat);
            10'd6:  return 16'({(qn == 0), 4'b0} | {m_full, 6'b0});
            10'd8:  return 16'(m_lpdiv);
            10'd9:  return m_idiv;
            10'd10: return 16'(m_fdiv);
            10'd11: return 16'(m_line);
            10'd12: return m_ctrl;
            10'd13: return 16'(m_lvl);
            10'd14: return 16'(m_mask);
            10'd15: return 16'({m_raw, 4'b0});
            10'd16: return 16'({m_raw & m_mask[4], 4'b0});
            10'd18: return 16'(m_dmac);
            default: return 16'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [9:0] a);
        if (a >= 10'h3F8) return "R9";
        case (a)
            10'd0, 10'd1: return "R4";
            10'd6:        return "R3";
            10'd14, 10'd16: return "R7";
            10'd15:       return "R6";
            10'd8, 10'd9, 10'd10, 10'd11, 10'd12, 10'd13, 10'd18: return "R8";
            default:      return "R9";
        endcase
    endfunction

    // one bus cycle: drive at negedge, check comb outputs, update model at the edge
    task automatic cyc(input bit pv, input logic [11:0] pc, input bit sel,
                       input bit we, input logic [9:0] a, input logic [15:0] wd);
        bit pacc, rdd, popm, flm, fen0;
        int trg;
        rx_valid = pv; rx_char = pc; reg_sel = sel; reg_we = we;
        reg_addr = a; reg_wdata = wd;
        #(P/4);
        chk(rx_ready == m_ready(), "R2", "rx_ready", int'(rx_ready), int'(m_ready()));
        if (sel && !we)
            chk(reg_rdata == m_read(a), req_of(a), $sformatf("read word 0x%0h", a),
                int'(reg_rdata), int'(m_read(a)));
        pacc = pv && m_ready();
        rdd  = sel && !we && (a == 10'd0);
        popm = rdd && (qn > 0);
        fen0 = m_fen();
        flm  = sel && we && (a == 10'd11) && (wd[4] != fen0);
        trg  = m_trig();
        @(posedge clk);
        if (sel && we) begin
            case (a)
                10'd8:  m_lpdiv = wd[7:0];
                10'd9:  m_idiv  = wd;
                10'd10: m_fdiv  = wd[5:0];
                10'd11: m_line  = wd[7:0];
                10'd12: m_ctrl  = wd;
                10'd13: m_lvl   = wd[5:0];
                10'd14: m_mask  = wd[10:0];
                10'd18: m_dmac  = wd[2:0];
                default: ;
            endcase
        end
        if (flm) begin
            qn = 0; qh = 0; m_full = 1'b0; m_raw = 1'b0;
        end else begin
            if (popm) begin
                m_last = q[qh]; m_stat = q[qh][11:8];
                qh = (qh + 1) % 16; qn--;
            end
            if (pacc) begin
                q[(qh + qn) % 16] = pc; qn++;
            end
            if (rdd) m_full = 1'b0;
            if (pacc && (!fen0 || qn == 16)) m_full = 1'b1;
            if (pacc && qn == trg) m_raw = 1'b1;
            else if (popm && qn == trg - 1) m_raw = 1'b0;
        end
        @(negedge clk);
        rx_valid = 1'b0; reg_sel = 1'b0; reg_we = 1'b0;
        chk(rx_empty == (qn == 0), "R3", "rx_empty", int'(rx_empty), int'(qn == 0));
        chk(rx_full == m_full, "R3", "rx_full", int'(rx_full), int'(m_full));
        chk(irq == (m_raw && m_mask[4]), "R7", "irq", int'(irq), int'(m_raw && m_mask[4]));
    endtask

    task automatic push(input logic [11:0] c);
        cyc(1'b1, c, 1'b0, 1'b0, 10'd0, 16'd0);
    endtask

    task automatic rd(input logic [9:0] a);
        cyc(1'b0, 12'd0, 1'b1, 1'b0, a, 16'd0);
    endtask

    task automatic wr(input logic [9:0] a, input logic [15:0] d);
        cyc(1'b0, 12'd0, 1'b1, 1'b1, a, d);
    endtask

    initial begin
        #(P * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [9:0] wa [10];
        wa = '{10'd8, 10'd9, 10'd10, 10'd11, 10'd12, 10'd13, 10'd14, 10'd18, 10'd1, 10'd16};
        void'($urandom(32'd1234));
        qh = 0; qn = 0; m_lpdiv = 0; m_line = 0; m_idiv = 0; m_ctrl = 0;
        m_fdiv = 0; m_lvl = 6'h12; m_mask = 0; m_dmac = 0; m_raw = 0;
        m_full = 0; m_stat = 0; m_last = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #(P/4);
        // R1: reset state at the ports
        chk(rx_empty == 1'b1, "R1", "empty after reset", int'(rx_empty), 1);
        chk(rx_full == 1'b0, "R1", "full after reset", int'(rx_full), 0);
        chk(irq == 1'b0, "R1", "irq after reset", int'(irq), 0);
        chk(rx_ready == 1'b1, "R1", "ready after reset", int'(rx_ready), 1);
        @(negedge clk);
        rd(10'd11);
        rd(10'd13);

        // single-slot mode: one character then refusal
        push(12'h3A5);
        chk(rx_full == 1'b1, "R3", "single-slot full", int'(rx_full), 1);
        push(12'h0BB);
        chk(rx_ready == 1'b0, "R2", "single-slot refuses", int'(rx_ready), 0);
        rd(10'd0);
        rd(10'd1);
        // R5: empty read returns last, no underflow
        rd(10'd0);
        chk(rx_empty == 1'b1, "R5", "empty after empty read", int'(rx_empty), 1);

        // enable the buffer (toggle flushes), unmask receive, fill to threshold 8
        wr(10'd11, 16'h0010);
        wr(10'd14, 16'h0010);
        for (int i = 0; i < 8; i++) push(12'(i * 37 + 5));
        chk(irq == 1'b1, "R6", "irq at threshold", int'(irq), 1);
        rd(10'd0);
        chk(irq == 1'b0, "R6", "irq cleared below threshold", int'(irq), 0);
        for (int i = 0; i < 9; i++) push(12'(i * 91 + 300));
        chk(rx_full == 1'b1 && rx_ready == 1'b0, "R2", "full at 16",
            int'({rx_full, rx_ready}), 2);
        push(12'hFFF);
        // R10: toggle off flushes
        wr(10'd11, 16'h0000);
        chk(rx_empty == 1'b1 && irq == 1'b0, "R10", "flush on toggle",
            int'({rx_empty, irq}), 2);
        wr(10'd11, 16'h0010);
        rd(10'h3F8); rd(10'h3FF); rd(10'h3FC); rd(10'd17); rd(10'd200);
        wr(10'd15, 16'hFFFF);
        rd(10'd15);

        // random mix
        for (int n = 0; n < 5000; n++) begin
            int op;
            op = int'($urandom_range(0, 99));
            if (op < 42) begin
                cyc(1'b1, 12'($urandom), 1'b0, 1'b0, 10'd0, 16'd0);
            end else if (op < 66) begin
                rd(10'd0);
            end else if (op < 80) begin
                if ($urandom_range(0, 3) == 0) rd(10'($urandom));
                else if ($urandom_range(0, 2) == 0) rd(10'h3F8 + 10'($urandom_range(0, 7)));
                else rd(10'($urandom_range(0, 20)));
            end else if (op < 90) begin
                logic [9:0] a;
                logic [15:0] d;
                a = wa[$urandom_range(0, 9)];
                d = 16'($urandom);
                if (a == 10'd11 && $urandom_range(0, 3) != 0) d[4] = m_line[4];
                wr(a, d);
            end else begin
                cyc(1'b0, 12'd0, 1'b0, 1'b0, 10'd0, 16'd0);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule